// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Status

This block is the host-facing side of a clock/calendar subsystem. A byte bus with one address bit reaches a 128-entry byte register file through an index: a write to the even address picks the entry, and a read or write at the odd address then acts on that entry. Four entries are control registers with special rules. Entry 10 holds divider settings and a read-only busy bit, entry 11 holds interrupt enables and mode bits, entry 12 is the interrupt status, and entry 13 is a fixed status byte. All other entries are plain storage.

The timing units outside the block send one-cycle pulses when a periodic tick, an alarm match or an update-ended event occurs. The block records each event as a flag in the status register. It combines the flags with the enables to drive a level interrupt, and it clears the status when software reads it. The bus is a plain strobe interface with no back-pressure. Each strobe is taken in the cycle it is high. Read data is registered and holds until the next read. A read and a write must not be strobed in the same cycle; if they are, the write wins.

Top module: `cmos_regport`

## Requirements
- R1: A write to the even address (bus_addr = 0) stores bus_wdata[6:0] as the register index, so bit 7 is dropped. A read of the even address returns 0xFF.
- R2: An access at the odd address reads or writes the indexed entry, and general entries keep what was written. Read data appears on bus_rdata on the clock edge after the strobe and holds until the next read.
- R3: Writes to the status register (index 12) and to index 13 have no effect, and index 13 reads 0x80.
- R4: Bit 7 of the index-10 register follows busy_in, one cycle late, and writes do not change it. Bits 6:0 of the index-10 register are writable.
- R5: A read of index 12 returns the current status. It then clears the status to 0x00, and irq is low on the following cycle.
- R6: The status bits are: bit 7 = interrupt pending, bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, bits 3:0 = 0. The enables are at bit 6 (periodic), bit 5 (alarm) and bit 4 (update) of index 11. An event pulse always sets its flag. If its enable is set, the pulse also sets the pending bit and irq rises one cycle later.
- R7: A write to index 11 sets the pending bit and raises irq at once when an enable in the new value matches a flag that is already set. Otherwise the write clears the pending bit and lowers irq, and the flags are kept.
- R8: A write to index 11 with bit 7 set stores bit 4 as 0, whatever the written value.
- R9: After power-on reset the registers read index 10 = 0x26, index 11 = 0x02, index 12 = 0x00 and index 13 = 0x80, and irq is low.
- R10: A pulse on warm_rst clears bits 6, 5 and 3 of index 11 and all of index 12, and lowers irq. The other bits and registers are kept.
- R11: An event pulse that arrives in the same cycle as a read of index 12 is not lost. The read returns the old status, and the new flag, and the pending bit if enabled, are present afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset that clears enables and flags |
| bus_addr | input | 1 | 0 selects the index, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| busy_in | input | 1 | Update-in-progress level from the timing unit |
| pf_pulse | input | 1 | Periodic event pulse |
| af_pulse | input | 1 | Alarm event pulse |
| uf_pulse | input | 1 | Update-ended event pulse |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, high while the pending bit is set |

## Verification
Every result is due exactly one clock after its stimulus. Read data, register changes, the clear on a status read and irq all change on the first rising edge after the strobe or pulse, because each passes through a single register stage. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares bus_rdata and irq with the model on the next falling edge, so every comparison falls one edge after the cause. The directed checks sample at the same point. The same-cycle cases are placed on one edge on purpose: a status read together with an event pulse, and a warm reset.

// File: rtl/cmos_regport_pkg.sv
package cmos_regport_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned SEL_DIV  = 10;
  localparam int unsigned SEL_CTL  = 11;
  localparam int unsigned SEL_STAT = 12;
  localparam int unsigned SEL_FIX  = 13;

  localparam int BIT_PEND = 7;
  localparam int BIT_SETM = 7;
  localparam int BIT_UEN  = 4;

  localparam byte_t DIV_INIT  = 8'h26;
  localparam byte_t CTL_INIT  = 8'h02;
  localparam byte_t FIX_INIT  = 8'h80;
  localparam byte_t CTL_WARM_KEEP = 8'h97;
  localparam byte_t EVT_MASK  = 8'h70;
endpackage

// File: rtl/rp_index.sv
module rp_index #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [7:0]       din,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx <= '0;
    else if (ld) idx <= din[IDX_W-1:0];
  end
endmodule

// File: rtl/rp_ctrl.sv
module rp_ctrl
  import cmos_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  byte_t            wdata,
  input  byte_t            ctl_wval,
  input  logic             busy,
  output byte_t            reg_div,
  output byte_t            reg_ctl,
  output byte_t            reg_fix,
  output byte_t            gp_q
);
  localparam int DEPTH = 1 << IDX_W;

  byte_t mem [DEPTH];
  logic  hit_div, hit_ctl, hit_sp;

  assign hit_div = (idx == IDX_W'(SEL_DIV));
  assign hit_ctl = (idx == IDX_W'(SEL_CTL));
  assign hit_sp  = hit_div || hit_ctl ||
                   (idx == IDX_W'(SEL_STAT)) || (idx == IDX_W'(SEL_FIX));

  always_ff @(posedge clk) begin
    if (wr_en && !hit_sp) mem[idx] <= wdata;
  end
  assign gp_q = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_div <= DIV_INIT;
      reg_ctl <= CTL_INIT;
      reg_fix <= FIX_INIT;
    end else begin
      reg_div[7] <= busy;
      if (wr_en && hit_div) reg_div[6:0] <= wdata[6:0];
      if (warm)                   reg_ctl <= reg_ctl & CTL_WARM_KEEP;
      else if (wr_en && hit_ctl)  reg_ctl <= ctl_wval;
      reg_fix <= reg_fix;
    end
  end
endmodule

// File: rtl/rp_status.sv
module rp_status
  import cmos_regport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  warm,
  input  logic  rd_stat,
  input  logic  ctl_wr,
  input  byte_t ctl_wval,
  input  byte_t ctl_cur,
  input  logic  [2:0] evt,
  output byte_t reg_stat,
  output logic  irq
);
  logic [2:0] flags, base_flags, flags_n;
  logic       pend, base_pend, pend_n;

  always_comb begin
    base_flags = rd_stat ? 3'b000 : flags;
    base_pend  = rd_stat ? 1'b0   : pend;
    flags_n    = base_flags | evt;
    if (ctl_wr) pend_n = |(ctl_wval[6:4] & flags_n);
    else        pend_n = base_pend | (|(ctl_cur[6:4] & evt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      pend  <= 1'b0;
    end else if (warm) begin
      flags <= '0;
      pend  <= 1'b0;
    end else begin
      flags <= flags_n;
      pend  <= pend_n;
    end
  end

  assign reg_stat = {pend, flags, 4'b0000};
  assign irq      = pend;
endmodule

// File: rtl/cmos_regport.sv
module cmos_regport
  import cmos_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warm_rst,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       busy_in,
  input  logic       pf_pulse,
  input  logic       af_pulse,
  input  logic       uf_pulse,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic [IDX_W-1:0] idx_q;
  byte_t reg_div, reg_ctl, reg_fix, reg_stat, gp_q, ctl_wval, rd_mux;
  logic  wr_data, wr_idx, rd_data, rd_any, ctl_wr, rd_stat;

  assign wr_idx  = bus_wr && !bus_addr;
  assign wr_data = bus_wr && bus_addr;
  assign rd_any  = bus_rd && !bus_wr;
  assign rd_data = rd_any && bus_addr;
  assign ctl_wr  = wr_data && (idx_q == IDX_W'(SEL_CTL)) && !warm_rst;
  assign rd_stat = rd_data && (idx_q == IDX_W'(SEL_STAT));

  always_comb begin
    ctl_wval = bus_wdata;
    if (bus_wdata[BIT_SETM]) ctl_wval[BIT_UEN] = 1'b0;
  end

  rp_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .ld(wr_idx), .din(bus_wdata), .idx(idx_q)
  );

  rp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .warm(warm_rst), .wr_en(wr_data), .idx(idx_q),
    .wdata(bus_wdata), .ctl_wval(ctl_wval), .busy(busy_in),
    .reg_div(reg_div), .reg_ctl(reg_ctl), .reg_fix(reg_fix), .gp_q(gp_q)
  );

  rp_status u_status (
    .clk(clk), .rst_n(rst_n), .warm(warm_rst), .rd_stat(rd_stat),
    .ctl_wr(ctl_wr), .ctl_wval(ctl_wval), .ctl_cur(reg_ctl),
    .evt({pf_pulse, af_pulse, uf_pulse}), .reg_stat(reg_stat), .irq(irq)
  );

  always_comb begin
    if (idx_q == IDX_W'(SEL_DIV))       rd_mux = reg_div;
    else if (idx_q == IDX_W'(SEL_CTL))  rd_mux = reg_ctl;
    else if (idx_q == IDX_W'(SEL_STAT)) rd_mux = reg_stat;
    else if (idx_q == IDX_W'(SEL_FIX))  rd_mux = reg_fix;
    else                                rd_mux = gp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_any) bus_rdata <= bus_addr ? rd_mux : 8'hFF;
  end
endmodule

// File: rtl/cmos_regport_chk.sv
module cmos_regport_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             warm_rst,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             pf_pulse,
  input logic             af_pulse,
  input logic             uf_pulse,
  input logic [7:0]       bus_rdata,
  input logic             irq,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       reg_ctl,
  input logic [7:0]       reg_fix
);
  logic at_ctl, at_stat, at_fix, any_evt;
  assign at_ctl  = (idx_q == IDX_W'(11));
  assign at_stat = (idx_q == IDX_W'(12));
  assign at_fix  = (idx_q == IDX_W'(13));
  assign any_evt = pf_pulse || af_pulse || uf_pulse;

  assert_even_read_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_addr) |=> (bus_rdata == 8'hFF));

  assert_fixed_ignores_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && at_fix) |=> $stable(reg_fix));

  assert_stat_read_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr && at_stat && !any_evt) |=> !irq);

  assert_enabled_event_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst && !(bus_wr && bus_addr && at_ctl) &&
     ((pf_pulse && reg_ctl[6]) || (af_pulse && reg_ctl[5]) || (uf_pulse && reg_ctl[4])))
    |=> irq);

  assert_setmode_masks_uen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst && bus_wr && bus_addr && at_ctl && bus_wdata[7]) |=> !reg_ctl[4]);

  assert_warm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (!irq && reg_ctl[6:5] == 2'b00 && !reg_ctl[3]));
endmodule

bind cmos_regport cmos_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .pf_pulse(pf_pulse), .af_pulse(af_pulse), .uf_pulse(uf_pulse),
  .bus_rdata(bus_rdata), .irq(irq), .idx_q(idx_q), .reg_ctl(reg_ctl),
  .reg_fix(reg_fix)
);

// File: tb/cmos_regport_tb.sv
module cmos_regport_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warm_rst = 1'b0, bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic busy_in = 1'b0, pf_pulse = 1'b0, af_pulse = 1'b0, uf_pulse = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq;

  int total = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  always #10 clk = ~clk;

  cmos_regport u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .busy_in(busy_in),
    .pf_pulse(pf_pulse), .af_pulse(af_pulse), .uf_pulse(uf_pulse),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [7:0] m_mem [128];
  int m_idx;
  logic [7:0] m_div, m_ctl, m_stat, m_fix, m_rdata;
  logic m_irq;

  function automatic logic [7:0] m_look(int i);
    case (i)
      10: return m_div;
      11: return m_ctl;
      12: return m_stat;
      13: return m_fix;
      default: return m_mem[i];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] nst, ev, bv;
    if (!rst_n) begin
      m_idx = 0; m_div = 8'h26; m_ctl = 8'h02; m_stat = 8'h00;
      m_fix = 8'h80; m_rdata = 8'h00; m_irq = 1'b0;
    end else begin
      ev = {1'b0, pf_pulse, af_pulse, uf_pulse, 4'b0000};
      if (bus_rd && !bus_wr) m_rdata = bus_addr ? m_look(m_idx) : 8'hFF;
      nst = (bus_rd && !bus_wr && bus_addr && m_idx == 12) ? 8'h00 : m_stat;
      if (warm_rst) begin
        m_ctl = m_ctl & 8'h97;
        nst = 8'h00;
      end else begin
        nst = nst | ev;
        if (bus_wr && bus_addr && m_idx == 11) begin
          bv = bus_wdata;
          if (bv[7]) bv[4] = 1'b0;
          m_ctl = bv;
          nst[7] = |(bv & nst & 8'h70);
        end else if (|(m_ctl & ev)) begin
          nst[7] = 1'b1;
        end
      end
      m_stat = nst;
      if (bus_wr && !bus_addr) m_idx = int'(bus_wdata & 8'h7F);
      if (bus_wr && bus_addr) begin
        if (m_idx == 10) m_div[6:0] = bus_wdata[6:0];
        else if (m_idx > 13 || m_idx < 10) m_mem[m_idx] = bus_wdata;
      end
      m_div[7] = busy_in;
      m_irq = m_stat[7];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (bus_rdata !== m_rdata || irq !== m_irq) begin
        fails++;
        $display("FAIL %s model compare: actual rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                 cur_req, bus_rdata, irq, m_rdata, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bwr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic rdreg(input logic [7:0] i, output logic [7:0] v);
    bwr(1'b0, i);
    brd(1'b1, v);
  endtask

  task automatic evt(input logic p, input logic a, input logic u);
    @(negedge clk); pf_pulse = p; af_pulse = a; uf_pulse = u;
    @(negedge clk); pf_pulse = 1'b0; af_pulse = 1'b0; uf_pulse = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R9";
    rdreg(8'd10, v); chk("R9", v, 8'h26);
    rdreg(8'd11, v); chk("R9", v, 8'h02);
    rdreg(8'd12, v); chk("R9", v, 8'h00);
    rdreg(8'd13, v); chk("R9", v, 8'h80);
    chk("R9", {7'd0, irq}, 8'h00);

    cur_req = "R1";
    bwr(1'b0, 8'h8B); brd(1'b1, v); chk("R1", v, 8'h02);
    brd(1'b0, v); chk("R1", v, 8'hFF);

    cur_req = "R2";
    bwr(1'b0, 8'h30); bwr(1'b1, 8'h5A);
    bwr(1'b0, 8'h31); bwr(1'b1, 8'hC3);
    rdreg(8'h30, v); chk("R2", v, 8'h5A);
    rdreg(8'h31, v); chk("R2", v, 8'hC3);
    repeat (2) @(negedge clk); chk("R2", bus_rdata, 8'hC3);

    cur_req = "R3";
    bwr(1'b0, 8'd12); bwr(1'b1, 8'hFF); brd(1'b1, v); chk("R3", v, 8'h00);
    bwr(1'b0, 8'd13); bwr(1'b1, 8'h00); brd(1'b1, v); chk("R3", v, 8'h80);

    cur_req = "R4";
    busy_in = 1'b1;
    bwr(1'b0, 8'd10); bwr(1'b1, 8'h25); brd(1'b1, v); chk("R4", v, 8'hA5);
    busy_in = 1'b0;
    bwr(1'b1, 8'hAA); brd(1'b1, v); chk("R4", v, 8'h2A);

    cur_req = "R6";
    evt(1'b0, 1'b0, 1'b1); chk("R6", {7'd0, irq}, 8'h00);
    rdreg(8'd12, v); chk("R6", v, 8'h10);
    bwr(1'b0, 8'd11); bwr(1'b1, 8'h42);
    evt(1'b1, 1'b0, 1'b0); chk("R6", {7'd0, irq}, 8'h01);

    cur_req = "R5";
    rdreg(8'd12, v); chk("R5", v, 8'hC0);
    chk("R5", {7'd0, irq}, 8'h00);
    brd(1'b1, v); chk("R5", v, 8'h00);

    cur_req = "R7";
    evt(1'b0, 1'b1, 1'b0); chk("R7", {7'd0, irq}, 8'h00);
    bwr(1'b0, 8'd11); bwr(1'b1, 8'h62); chk("R7", {7'd0, irq}, 8'h01);
    bwr(1'b1, 8'h02); chk("R7", {7'd0, irq}, 8'h00);
    rdreg(8'd12, v); chk("R7", v, 8'h20);

    cur_req = "R8";
    evt(1'b0, 1'b0, 1'b1);
    bwr(1'b0, 8'd11); bwr(1'b1, 8'h90); chk("R8", {7'd0, irq}, 8'h00);
    brd(1'b1, v); chk("R8", v, 8'h80);
    bwr(1'b1, 8'h10); chk("R8", {7'd0, irq}, 8'h01);
    bwr(1'b1, 8'h42);
    rdreg(8'd12, v); chk("R8", v, 8'h10);

    cur_req = "R11";
    bwr(1'b0, 8'd12);
    @(negedge clk); bus_addr = 1'b1; bus_rd = 1'b1; pf_pulse = 1'b1;
    @(negedge clk); bus_rd = 1'b0; pf_pulse = 1'b0;
    chk("R11", bus_rdata, 8'h00);
    chk("R11", {7'd0, irq}, 8'h01);
    brd(1'b1, v); chk("R11", v, 8'hC0);

    cur_req = "R10";
    bwr(1'b0, 8'd11); bwr(1'b1, 8'h6A);
    evt(1'b1, 1'b0, 1'b0); chk("R10", {7'd0, irq}, 8'h01);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    chk("R10", {7'd0, irq}, 8'h00);
    rdreg(8'd11, v); chk("R10", v, 8'h02);
    rdreg(8'd12, v); chk("R10", v, 8'h00);
    rdreg(8'd10, v); chk("R10", v, 8'h2A);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule